// File: doc/BRIEF.md
# Address-Threshold Write-Protect Controller

This block decides whether each instruction aimed at a small non-volatile word array may proceed. Its input is an instruction that has already been decoded and presented for one cycle. The instruction carries an opcode, a target address and the two mode pins sampled while it was loaded: a protect-select pin and a program-enable pin. One cycle later the block raises exactly one of two pulses. A grant pulse lets the surrounding logic run the operation. An abort pulse tells it to drop the operation and leave the array untouched.

Protection is set by a single threshold register. While that register holds a valid value, every address at or above it refuses erase and write. Changing the threshold takes a strict ritual. An arm instruction must come directly before the change, and the threshold must first be cleared before a new value can be loaded. A one-time lock freezes the threshold for good. The block also keeps the general erase/write enable latch and the one-shot arm flag.

The threshold, its valid bit and the lock bit stand for non-volatile state. They start cleared at power-up and keep their values across reset. Serial shifting, array storage and programming timing are handled by other blocks.

Top module: `wpg_guard`

## Requirements
- R1: When the enable latch is set and protect-select is low, an erase (opcode 3) or write (opcode 4) is granted if the threshold is invalid or the address is below it. An address equal to or above a valid threshold is aborted.
- R2: Erase-all (opcode 5) and write-all (opcode 6) are granted only while the threshold is invalid and the enable latch is set. Otherwise they are aborted.
- R3: The arm instruction (opcode 7) is granted only with the enable latch set and both mode pins high. A granted arm sets the arm flag; an aborted arm clears it.
- R4: The arm flag stays set for exactly one following instruction, whatever that instruction is. Protect-clear (8), protect-set (9) and protect-lock (10) are aborted unless the arm flag is set when they arrive.
- R5: Protect-set is granted only while the threshold is invalid. It loads the instruction address as the threshold and marks it valid. A threshold of 0 protects every address.
- R6: Protect-clear, protect-set and protect-lock are aborted unless both mode pins are high. A granted protect-clear makes the threshold invalid.
- R7: A granted protect-lock sets the lock bit permanently. From then on, protect-clear and protect-set are aborted and the threshold does not change. The lock bit and the threshold keep their values through reset.
- R8: Read (0), enable (1), disable (2), erase, write, erase-all and write-all are aborted when protect-select is high. Enable sets the latch and disable clears it.
- R9: Every instruction yields exactly one response on the next cycle: a one-cycle grant or a one-cycle abort. Opcodes 12 to 15 are aborted, and idle cycles give no pulse.
- R10: Reset clears the enable latch, the arm flag and both response pulses.
- R11: Protect-read (opcode 11) is granted when protect-select is high and aborted otherwise. The threshold value and its valid bit are always visible on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid_i | input | 1 | A decoded instruction is present this cycle |
| op_code_i | input | 4 | Instruction opcode |
| op_addr_i | input | AW | Target address, also the new threshold for protect-set |
| psel_i | input | 1 | Sampled protect-select pin |
| pgm_i | input | 1 | Sampled program-enable pin |
| grant_o | output | 1 | One-cycle pulse: the instruction may proceed |
| abort_o | output | 1 | One-cycle pulse: the instruction is refused |
| wen_o | output | 1 | Erase/write enable latch |
| arm_o | output | 1 | One-shot protect arm flag |
| thr_o | output | AW | Current protect threshold |
| thr_valid_o | output | 1 | Threshold holds a valid value |
| locked_o | output | 1 | Threshold is permanently frozen |

## Verification
Some rules are checked by assertions on every cycle:
- one response per instruction, and none when idle;
- aborts for addresses at or above a valid threshold;
- aborts for whole-array operations while a threshold is valid;
- aborts for ordinary instructions with protect-select high;
- aborts for protect changes that arrive without the arm flag;
- a frozen threshold once locked.

Other rules need ordered sequences that only the directed scenarios can show:
- the arm flag being used up by an unrelated instruction placed in between;
- the need to clear before setting a new threshold;
- a threshold of zero protecting every address;
- the lock and threshold surviving a reset while the enable latch is cleared.

// File: rtl/wpg_pkg.sv
// Shared opcode encoding and verdict type for the write-protect controller.
package wpg_pkg;

    typedef enum logic [3:0] {
        OP_READ      = 4'd0,
        OP_WREN      = 4'd1,
        OP_WRDIS     = 4'd2,
        OP_ERASE     = 4'd3,
        OP_WRITE     = 4'd4,
        OP_ERASE_ALL = 4'd5,
        OP_WRITE_ALL = 4'd6,
        OP_P_ARM     = 4'd7,
        OP_P_CLEAR   = 4'd8,
        OP_P_SET     = 4'd9,
        OP_P_LOCK    = 4'd10,
        OP_P_READ    = 4'd11
    } wp_op_e;

    // Outcome of one instruction and the state updates it causes
    typedef struct packed {
        logic grant;
        logic set_wen;
        logic clr_wen;
        logic arm;
        logic thr_clear;
        logic thr_load;
        logic lock;
    } verdict_t;

endpackage

// File: rtl/wpg_verdict.sv
// Combinational rule engine. For the instruction presented this cycle it
// decides grant or refusal and which state bits change.
// Assumes the inputs are stable for the cycle in which op_valid_i is high.
module wpg_verdict
    import wpg_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          op_valid_i,
    input  logic [3:0]    op_code_i,
    input  logic [AW-1:0] op_addr_i,
    input  logic          psel_i,
    input  logic          pgm_i,
    input  logic          wen_i,
    input  logic          arm_i,
    input  logic [AW-1:0] thr_i,
    input  logic          thr_valid_i,
    input  logic          locked_i,
    output verdict_t      v_o
);

    logic ord_ok;
    logic prot_ok;
    logic cmd_ok;
    logic addr_free;

    assign ord_ok    = !psel_i;
    assign prot_ok   = psel_i && pgm_i;
    assign cmd_ok    = arm_i && prot_ok && !locked_i;
    assign addr_free = !thr_valid_i || (op_addr_i < thr_i);

    // Map the opcode and the current state to a verdict
    always_comb begin
        v_o = '0;
        if (op_valid_i) begin
            case (wp_op_e'(op_code_i))
                OP_READ:      v_o.grant = ord_ok;
                OP_WREN: begin
                    v_o.grant   = ord_ok;
                    v_o.set_wen = ord_ok;
                end
                OP_WRDIS: begin
                    v_o.grant   = ord_ok;
                    v_o.clr_wen = ord_ok;
                end
                OP_ERASE,
                OP_WRITE:     v_o.grant = ord_ok && wen_i && addr_free;
                OP_ERASE_ALL,
                OP_WRITE_ALL: v_o.grant = ord_ok && wen_i && !thr_valid_i;
                OP_P_ARM: begin
                    v_o.grant = prot_ok && wen_i;
                    v_o.arm   = prot_ok && wen_i;
                end
                OP_P_CLEAR: begin
                    v_o.grant     = cmd_ok;
                    v_o.thr_clear = cmd_ok;
                end
                OP_P_SET: begin
                    v_o.grant    = cmd_ok && !thr_valid_i;
                    v_o.thr_load = cmd_ok && !thr_valid_i;
                end
                OP_P_LOCK: begin
                    v_o.grant = cmd_ok;
                    v_o.lock  = cmd_ok;
                end
                OP_P_READ:    v_o.grant = psel_i;
                default:      v_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/wpg_latches.sv
// Volatile control state: the erase/write enable latch and the one-shot
// arm flag. Both are cleared by reset. Every instruction updates the arm
// flag, so the flag survives only into the next instruction.
module wpg_latches
    import wpg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     op_valid_i,
    input  verdict_t v_i,
    output logic     wen_o,
    output logic     arm_o
);

    // Update the enable latch and the arm flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_o <= 1'b0;
            arm_o <= 1'b0;
        end else begin
            if (v_i.set_wen)      wen_o <= 1'b1;
            else if (v_i.clr_wen) wen_o <= 1'b0;
            if (op_valid_i)       arm_o <= v_i.arm;
        end
    end

endmodule

// File: rtl/wpg_prot_reg.sv
// Non-volatile protect state: the threshold, its valid bit and the
// permanent lock. These start cleared at power-up and are not touched by
// reset. The verdict already carries the lock check.
module wpg_prot_reg
    import wpg_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  verdict_t      v_i,
    input  logic [AW-1:0] op_addr_i,
    output logic [AW-1:0] thr_o,
    output logic          thr_valid_o,
    output logic          locked_o
);

    logic [AW-1:0] thr_q   = '0;
    logic          valid_q = 1'b0;
    logic          lock_q  = 1'b0;

    // Apply protect-clear, protect-set and protect-lock
    always_ff @(posedge clk) begin
        if (v_i.thr_clear) valid_q <= 1'b0;
        if (v_i.thr_load) begin
            thr_q   <= op_addr_i;
            valid_q <= 1'b1;
        end
        if (v_i.lock) lock_q <= 1'b1;
    end

    assign thr_o       = thr_q;
    assign thr_valid_o = valid_q;
    assign locked_o    = lock_q;

    // R7
    lock_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q && $stable(thr_q) && $stable(valid_q));

endmodule

// File: rtl/wpg_guard.sv
// Top of the address-threshold write-protect controller. It registers a
// one-cycle grant or abort for each decoded instruction.
// Assumes op_valid_i is high for one cycle per instruction, with the
// address and the sampled pins valid in that cycle.
module wpg_guard
    import wpg_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid_i,
    input  logic [3:0]    op_code_i,
    input  logic [AW-1:0] op_addr_i,
    input  logic          psel_i,
    input  logic          pgm_i,
    output logic          grant_o,
    output logic          abort_o,
    output logic          wen_o,
    output logic          arm_o,
    output logic [AW-1:0] thr_o,
    output logic          thr_valid_o,
    output logic          locked_o
);

    verdict_t v;
    wp_op_e   op_e;

    assign op_e = wp_op_e'(op_code_i);

    wpg_verdict #(.AW(AW)) u_verdict (
        .op_valid_i  (op_valid_i),
        .op_code_i   (op_code_i),
        .op_addr_i   (op_addr_i),
        .psel_i      (psel_i),
        .pgm_i       (pgm_i),
        .wen_i       (wen_o),
        .arm_i       (arm_o),
        .thr_i       (thr_o),
        .thr_valid_i (thr_valid_o),
        .locked_i    (locked_o),
        .v_o         (v)
    );

    wpg_latches u_latches (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid_i (op_valid_i),
        .v_i        (v),
        .wen_o      (wen_o),
        .arm_o      (arm_o)
    );

    wpg_prot_reg #(.AW(AW)) u_prot (
        .clk         (clk),
        .rst_n       (rst_n),
        .v_i         (v),
        .op_addr_i   (op_addr_i),
        .thr_o       (thr_o),
        .thr_valid_o (thr_valid_o),
        .locked_o    (locked_o)
    );

    // Register the response pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o <= 1'b0;
            abort_o <= 1'b0;
        end else begin
            grant_o <= v.grant;
            abort_o <= op_valid_i && !v.grant;
        end
    end

    // R9
    one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i |=> (grant_o ^ abort_o));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> !grant_o && !abort_o);

    // R1
    above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && (op_e == OP_ERASE || op_e == OP_WRITE)
        && thr_valid_o && (op_addr_i >= thr_o) |=> abort_o);

    // R2
    bulk_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && (op_e == OP_ERASE_ALL || op_e == OP_WRITE_ALL)
        && thr_valid_o |=> abort_o);

    // R8
    psel_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && (op_code_i <= 4'd6) && psel_i |=> abort_o);

    // R4
    unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && !arm_o
        && (op_e == OP_P_CLEAR || op_e == OP_P_SET || op_e == OP_P_LOCK)
        |=> abort_o);

    // R3
    arm_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && (op_e == OP_P_ARM) && !wen_o |=> abort_o && !arm_o);

endmodule

// File: tb/wpg_guard_tb.sv
module wpg_guard_tb;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [3:0]    op_code = '0;
    logic [AW-1:0] op_addr = '0;
    logic          psel = 1'b0;
    logic          pgm = 1'b0;
    logic          grant, abort_p, wen, arm, thr_valid, locked;
    logic [AW-1:0] thr;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wpg_guard #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_code_i(op_code),
        .op_addr_i(op_addr), .psel_i(psel), .pgm_i(pgm), .grant_o(grant),
        .abort_o(abort_p), .wen_o(wen), .arm_o(arm), .thr_o(thr),
        .thr_valid_o(thr_valid), .locked_o(locked)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Present one instruction, then sample its response one edge later
    task automatic issue(input logic [3:0] c, input logic [AW-1:0] a,
                         input logic ps, input logic pg, input logic exp_grant,
                         input string tag);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; op_addr = a; psel = ps; pgm = pg;
        @(negedge clk);
        op_valid = 1'b0; psel = 1'b0; pgm = 1'b0;
        chk({grant, abort_p}, {exp_grant, !exp_grant}, tag);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk({grant, abort_p, wen, arm}, 4'b0, "R10 reset outputs");
        chk({thr_valid, locked}, 2'b0, "R7 power-up protect state");
        @(negedge clk);
        chk({grant, abort_p}, 2'b0, "R9 idle no pulse");
    endtask

    task automatic t_enable_and_write();
        issue(4'd4, 8'h10, 0, 0, 0, "R1 write without enable aborted");
        issue(4'd1, 8'h00, 0, 0, 1, "R8 enable granted");
        chk(wen, 1, "R8 latch set");
        issue(4'd4, 8'hFF, 0, 0, 1, "R1 write with no threshold");
        issue(4'd3, 8'h00, 0, 0, 1, "R1 erase with no threshold");
        issue(4'd6, 8'h00, 0, 0, 1, "R2 write-all cleared threshold");
        issue(4'd13, 8'h00, 0, 0, 0, "R9 reserved opcode aborted");
    endtask

    task automatic t_psel_ordinary();
        issue(4'd4, 8'h10, 1, 0, 0, "R8 write with psel high");
        issue(4'd0, 8'h10, 1, 0, 0, "R8 read with psel high");
        issue(4'd0, 8'h10, 0, 0, 1, "R8 read with psel low");
    endtask

    task automatic t_set_threshold();
        issue(4'd7, 8'h00, 1, 0, 0, "R3 arm with pgm low");
        chk(arm, 0, "R3 arm flag clear");
        issue(4'd9, 8'h40, 1, 1, 0, "R4 set without arm");
        issue(4'd7, 8'h00, 1, 1, 1, "R3 arm granted");
        chk(arm, 1, "R3 arm flag set");
        issue(4'd9, 8'h40, 1, 0, 0, "R6 set with pgm low");
        chk(arm, 0, "R4 arm consumed");
        issue(4'd7, 8'h00, 1, 1, 1, "R3 re-arm");
        issue(4'd9, 8'h40, 1, 1, 1, "R5 set granted");
        chk({thr_valid, thr}, {1'b1, 8'h40}, "R5 threshold loaded");
        issue(4'd4, 8'h3F, 0, 0, 1, "R1 below threshold granted");
        issue(4'd4, 8'h40, 0, 0, 0, "R1 at threshold aborted");
        issue(4'd3, 8'hFF, 0, 0, 0, "R1 above threshold aborted");
        issue(4'd5, 8'h00, 0, 0, 0, "R2 erase-all with threshold");
        issue(4'd6, 8'h00, 0, 0, 0, "R2 write-all with threshold");
    endtask

    task automatic t_clear_rules();
        issue(4'd7, 8'h00, 1, 1, 1, "R4 arm");
        issue(4'd9, 8'h20, 1, 1, 0, "R5 set needs prior clear");
        chk(thr, 8'h40, "R5 threshold unchanged");
        issue(4'd7, 8'h00, 1, 1, 1, "R4 arm again");
        issue(4'd0, 8'h00, 0, 0, 1, "R4 intervening read");
        issue(4'd8, 8'h00, 1, 1, 0, "R4 clear after gap aborted");
        chk(thr_valid, 1, "R4 threshold still valid");
        issue(4'd7, 8'h00, 1, 1, 1, "R6 arm");
        issue(4'd8, 8'h00, 1, 1, 1, "R6 clear granted");
        chk(thr_valid, 0, "R6 threshold invalid");
        issue(4'd5, 8'h00, 0, 0, 1, "R2 erase-all after clear");
    endtask

    task automatic t_zero_threshold();
        issue(4'd7, 8'h00, 1, 1, 1, "R5 arm");
        issue(4'd9, 8'h00, 1, 1, 1, "R5 set zero");
        issue(4'd4, 8'h00, 0, 0, 0, "R5 zero threshold protects addr 0");
        issue(4'd11, 8'h00, 1, 0, 1, "R11 read threshold granted");
        issue(4'd11, 8'h00, 0, 0, 0, "R11 read threshold psel low");
        chk({thr_valid, thr}, {1'b1, 8'h00}, "R11 threshold visible");
        issue(4'd7, 8'h00, 1, 1, 1, "R6 arm");
        issue(4'd8, 8'h00, 1, 1, 1, "R6 clear");
    endtask

    task automatic t_lock();
        issue(4'd7, 8'h00, 1, 1, 1, "R7 arm");
        issue(4'd9, 8'h80, 1, 1, 1, "R7 set 80");
        issue(4'd7, 8'h00, 1, 1, 1, "R7 arm");
        issue(4'd10, 8'h00, 1, 1, 1, "R7 lock granted");
        chk(locked, 1, "R7 locked");
        issue(4'd7, 8'h00, 1, 1, 1, "R7 arm after lock");
        issue(4'd8, 8'h00, 1, 1, 0, "R7 clear after lock aborted");
        chk({thr_valid, thr}, {1'b1, 8'h80}, "R7 threshold frozen");
        do_reset();
        chk({locked, thr_valid, thr}, {2'b11, 8'h80}, "R7 survives reset");
        chk({wen, arm}, 2'b00, "R10 latch cleared by reset");
        issue(4'd7, 8'h00, 1, 1, 0, "R3 arm without enable");
        issue(4'd1, 8'h00, 0, 0, 1, "R8 enable");
        issue(4'd2, 8'h00, 0, 0, 1, "R8 disable");
        chk(wen, 0, "R8 latch cleared");
        issue(4'd4, 8'h10, 0, 0, 0, "R1 write after disable");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_enable_and_write();
        t_psel_ordinary();
        t_set_threshold();
        t_clear_rules();
        t_zero_threshold();
        t_lock();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule